// File: doc/BRIEF.md
# PIM Instruction Dispatch and Unroll Unit

This block sits between a host instruction stream and the per-channel memory controllers of a processing-in-memory device. It takes one instruction per valid/ready handshake. Each instruction carries an opcode, a channel bitmask, an operand size, a bank, a row, a starting column and a register index. The block expands the instruction into a sequence of single-beat memory requests. Each request moves one 256-bit beat, which is one general-purpose register of 16 FP16 lanes. The requests go out one at a time on a valid/ready request port.

For every channel whose mask bit is set, the unit issues one request per column. Channels are visited in ascending index order. Within a channel the column starts at the given column and rises by one for each beat. Sized opcodes take the beat count from the operand-size field. All other request opcodes issue a single beat.

Barrier-type opcodes freeze the instruction port until the downstream controller reports completion with a one-cycle pulse. These are the MAC-result read, the activation read, the barrier and end-of-compute. The all-bank write must name exactly one channel; any other mask is rejected and recorded in a sticky error flag. End-of-compute raises a permanent done flag once it completes.

Top module: `pim_dispatch`

## Requirements
- R1: After reset `in_ready_o` is 1, and `req_valid_o`, `err_o` and `done_o` are 0.
- R2: For an accepted instruction, requests are issued for exactly the channels whose bits are set in `in_mask_i`, in ascending channel index order, with `req_chan_o` holding that index.
- R3: Sized opcodes issue `in_opsize_i + 1` beats per channel; every other request opcode issues 1 beat. The sized opcode codes are 2, 7, 8, 9, 10, 12 and 13. Beat k of a channel carries column `in_col_i + k` modulo 2^COLW.
- R4: An all-bank write (opcode 1) whose mask does not have exactly one bit set is dropped without requests, and it sets `err_o`, which then stays 1 until reset.
- R5: Blocking opcodes hold `in_ready_o` at 0 after their last request (or right after acceptance if they issue none) until `cmpl_i` is sampled high. `in_ready_o` is 1 in the cycle after that. The blocking codes are 4, 5, 14 and 15.
- R6: After end-of-compute (opcode 15) completes, `done_o` is 1 and stays 1, and no further instruction is accepted.
- R7: `in_ready_o` is 0 while any request of the current instruction is pending.
- R8: `req_last_o` is 1 only on the final request of an instruction, that is, the last beat of the highest selected channel.
- R9: Each request carries the bank, row, opcode and register index of its instruction.
- R10: While `req_valid_o` is 1 and `req_ready_i` is 0, the request and all its fields hold steady.
- R11: The barrier (14) and end-of-compute (15) issue no requests. A request opcode with an empty mask issues none either, and if it is non-blocking the unit is ready again in the next cycle.
- R12: A `cmpl_i` pulse while the unit is not waiting on a blocking opcode has no effect on `in_ready_o` or `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Instruction accepted when high together with valid |
| in_op_i | input | 4 | Opcode |
| in_mask_i | input | NCH (32) | Target channel bitmask |
| in_opsize_i | input | OPSW (4) | Operand size; beats per channel minus one for sized opcodes |
| in_bank_i | input | BANKW (4) | Bank index |
| in_row_i | input | ROWW (14) | Row address |
| in_col_i | input | COLW (6) | Starting column |
| in_gpr_i | input | GPRW (3) | Register index |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by downstream |
| req_chan_o | output | 5 | Target channel index |
| req_bank_o | output | BANKW | Bank of the request |
| req_row_o | output | ROWW | Row of the request |
| req_col_o | output | COLW | Column of the request |
| req_op_o | output | 4 | Opcode of the request |
| req_gpr_o | output | GPRW | Register index of the request |
| req_last_o | output | 1 | Final request of the instruction |
| cmpl_i | input | 1 | Completion pulse from the controller |
| err_o | output | 1 | Sticky illegal-mask flag |
| done_o | output | 1 | End-of-compute completed |

## Verification
The hardest situation to reach is a sized instruction whose mask covers both ends of the channel range while its columns wrap past the top of the column space and the downstream port stalls partway through a channel. Only that mix exercises the move to the next channel, the column wrap and the last-beat flag together with held requests. A directed case builds it on purpose. Random stimulus then adds sparse random masks, random operand sizes and a randomly stalling request port. It also mixes in all-bank writes whose masks are one-hot only part of the time, so that dropped and accepted instructions sit next to each other in the stream.

// File: rtl/pim_dispatch_pkg.sv
package pim_dispatch_pkg;
  typedef enum logic [3:0] {
    OP_WR_ONE   = 4'd0,
    OP_WR_ALL   = 4'd1,
    OP_WR_GBUF  = 4'd2,
    OP_WR_BIAS  = 4'd3,
    OP_RD_MACC  = 4'd4,
    OP_RD_ACTV  = 4'd5,
    OP_RD_ONE   = 4'd6,
    OP_CP_BK_GB = 4'd7,
    OP_CP_GB_BK = 4'd8,
    OP_MAC_ONE  = 4'd9,
    OP_MAC_ALL  = 4'd10,
    OP_ACT_FN   = 4'd11,
    OP_EW_MUL   = 4'd12,
    OP_EW_ADD   = 4'd13,
    OP_BARRIER  = 4'd14,
    OP_END      = 4'd15
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_DONE} st_e;
endpackage

// File: rtl/pim_op_decode.sv
module pim_op_decode
  import pim_dispatch_pkg::*;
(
  input  logic [3:0] op_i,
  output logic       sized_o,
  output logic       block_o,
  output logic       emits_o,
  output logic       allbank_o,
  output logic       end_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    sized_o = 1'b0;
    block_o = 1'b0;
    emits_o = 1'b1;
    unique case (op)
      OP_WR_GBUF, OP_CP_BK_GB, OP_CP_GB_BK, OP_MAC_ONE,
      OP_MAC_ALL, OP_EW_MUL, OP_EW_ADD:  sized_o = 1'b1;
      OP_RD_MACC, OP_RD_ACTV:            block_o = 1'b1;
      OP_BARRIER, OP_END: begin
        block_o = 1'b1;
        emits_o = 1'b0;
      end
      default: ;
    endcase
  end

  assign allbank_o = (op == OP_WR_ALL);
  assign end_o     = (op == OP_END);
endmodule

// File: rtl/pim_chan_pick.sv
module pim_chan_pick #(
  parameter int NCH = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask_i,
  output logic           any_o,
  output logic           single_o,  // at most one bit set
  output logic [CHW-1:0] idx_o,
  output logic [NCH-1:0] rest_o
);
  assign any_o    = |mask_i;
  assign rest_o   = mask_i & (mask_i - NCH'(1));
  assign single_o = ~|rest_o;

  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = CHW'(i);
    end
  end
endmodule

// File: rtl/pim_beat_ctr.sv
module pim_beat_ctr #(
  parameter int CNTW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CNTW-1:0] cnt_i,    // beats per channel, >= 1
  input  logic            step_i,
  output logic [CNTW-1:0] beat_o,
  output logic            last_o
);
  logic [CNTW-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o <= '0;
      lim_q  <= '0;
    end else if (load_i) begin
      beat_o <= '0;
      lim_q  <= cnt_i - CNTW'(1);
    end else if (step_i) begin
      beat_o <= last_o ? '0 : beat_o + CNTW'(1);
    end
  end

  assign last_o = (beat_o == lim_q);
endmodule

// File: rtl/pim_dispatch.sv
module pim_dispatch
  import pim_dispatch_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int BANKW = 4,
  parameter int ROWW  = 14,
  parameter int COLW  = 6,
  parameter int OPSW  = 4,
  parameter int GPRW  = 3,
  localparam int CHW  = $clog2(NCH),
  localparam int CNTW = OPSW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [3:0]       in_op_i,
  input  logic [NCH-1:0]   in_mask_i,
  input  logic [OPSW-1:0]  in_opsize_i,
  input  logic [BANKW-1:0] in_bank_i,
  input  logic [ROWW-1:0]  in_row_i,
  input  logic [COLW-1:0]  in_col_i,
  input  logic [GPRW-1:0]  in_gpr_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [CHW-1:0]   req_chan_o,
  output logic [BANKW-1:0] req_bank_o,
  output logic [ROWW-1:0]  req_row_o,
  output logic [COLW-1:0]  req_col_o,
  output logic [3:0]       req_op_o,
  output logic [GPRW-1:0]  req_gpr_o,
  output logic             req_last_o,
  input  logic             cmpl_i,
  output logic             err_o,
  output logic             done_o
);
  st_e st_q;

  logic [NCH-1:0]   mask_q;
  logic [3:0]       op_q;
  logic [BANKW-1:0] bank_q;
  logic [ROWW-1:0]  row_q;
  logic [COLW-1:0]  col_q;
  logic [GPRW-1:0]  gpr_q;
  logic             err_q;

  // incoming instruction
  logic in_sized, in_block, in_emits, in_allbank, in_end;
  logic in_any, in_single;
  logic [CHW-1:0] in_idx_unused;
  logic [NCH-1:0] in_rest_unused;

  pim_op_decode u_dec_in (
    .op_i(in_op_i), .sized_o(in_sized), .block_o(in_block),
    .emits_o(in_emits), .allbank_o(in_allbank), .end_o(in_end)
  );

  pim_chan_pick #(.NCH(NCH)) u_pick_in (
    .mask_i(in_mask_i), .any_o(in_any), .single_o(in_single),
    .idx_o(in_idx_unused), .rest_o(in_rest_unused)
  );

  // held instruction
  logic q_sized, q_block, q_emits, q_allbank, q_end;
  logic cur_any, cur_single;
  logic [CHW-1:0] cur_idx;
  logic [NCH-1:0] cur_rest;

  pim_op_decode u_dec_q (
    .op_i(op_q), .sized_o(q_sized), .block_o(q_block),
    .emits_o(q_emits), .allbank_o(q_allbank), .end_o(q_end)
  );

  pim_chan_pick #(.NCH(NCH)) u_pick_cur (
    .mask_i(mask_q), .any_o(cur_any), .single_o(cur_single),
    .idx_o(cur_idx), .rest_o(cur_rest)
  );

  logic accept, bad_mask, fire;
  logic [CNTW-1:0] beats;
  logic [CNTW-1:0] beat;
  logic            beat_last;

  assign accept   = in_valid_i && in_ready_o;
  assign bad_mask = in_allbank && !(in_any && in_single);
  assign fire     = req_valid_o && req_ready_i;
  assign beats    = in_sized ? ({1'b0, in_opsize_i} + CNTW'(1)) : CNTW'(1);

  pim_beat_ctr #(.CNTW(CNTW)) u_beat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept), .cnt_i(beats), .step_i(fire),
    .beat_o(beat), .last_o(beat_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      op_q   <= '0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      gpr_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (bad_mask) begin
            err_q <= 1'b1;
          end else begin
            mask_q <= in_mask_i;
            op_q   <= in_op_i;
            bank_q <= in_bank_i;
            row_q  <= in_row_i;
            col_q  <= in_col_i;
            gpr_q  <= in_gpr_i;
            if (in_emits && in_any) st_q <= ST_RUN;
            else if (in_block)      st_q <= ST_WAIT;
          end
        end
        ST_RUN: if (fire && beat_last) begin
          mask_q <= cur_rest;
          if (cur_single) st_q <= q_block ? ST_WAIT : ST_IDLE;
        end
        ST_WAIT: if (cmpl_i) st_q <= q_end ? ST_DONE : ST_IDLE;
        default: ;
      endcase
    end
  end

  logic [COLW+CNTW-1:0] col_sum;
  assign col_sum = {{CNTW{1'b0}}, col_q} + {{COLW{1'b0}}, beat};

  assign in_ready_o  = (st_q == ST_IDLE);
  assign req_valid_o = (st_q == ST_RUN);
  assign req_chan_o  = cur_idx;
  assign req_bank_o  = bank_q;
  assign req_row_o   = row_q;
  assign req_col_o   = col_sum[COLW-1:0];
  assign req_op_o    = op_q;
  assign req_gpr_o   = gpr_q;
  assign req_last_o  = beat_last && cur_single;
  assign err_o       = err_q;
  assign done_o      = (st_q == ST_DONE);

  logic unused_q;
  assign unused_q = q_sized ^ q_emits ^ q_allbank ^ cur_any ^ in_end
                  ^ (|in_idx_unused) ^ (|in_rest_unused);
endmodule

// File: rtl/pim_dispatch_chk.sv
module pim_dispatch_chk #(
  parameter int NCH   = 32,
  parameter int BANKW = 4,
  parameter int ROWW  = 14,
  parameter int COLW  = 6,
  parameter int GPRW  = 3,
  localparam int CHW  = $clog2(NCH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [CHW-1:0]   req_chan_o,
  input logic [BANKW-1:0] req_bank_o,
  input logic [ROWW-1:0]  req_row_o,
  input logic [COLW-1:0]  req_col_o,
  input logic [3:0]       req_op_o,
  input logic [GPRW-1:0]  req_gpr_o,
  input logic             req_last_o,
  input logic             err_o,
  input logic             done_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_chan_o)
      && $stable(req_col_o) && $stable(req_bank_o) && $stable(req_row_o)
      && $stable(req_op_o) && $stable(req_gpr_o) && $stable(req_last_o)); // R10

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !in_ready_o); // R7

  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i && req_last_o |=> !req_valid_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R4

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !in_ready_o && !req_valid_o); // R6
endmodule

bind pim_dispatch pim_dispatch_chk #(
  .NCH(NCH), .BANKW(BANKW), .ROWW(ROWW), .COLW(COLW), .GPRW(GPRW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_chan_o(req_chan_o), .req_bank_o(req_bank_o), .req_row_o(req_row_o),
  .req_col_o(req_col_o), .req_op_o(req_op_o), .req_gpr_o(req_gpr_o),
  .req_last_o(req_last_o), .err_o(err_o), .done_o(done_o)
);

// File: tb/pim_dispatch_tb.sv
module pim_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32, BANKW = 4, ROWW = 14, COLW = 6, OPSW = 4, GPRW = 3;
  localparam int CHW = 5;
  localparam int PW  = CHW + BANKW + ROWW + COLW + 4 + GPRW + 1;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [3:0] in_op = '0;
  logic [NCH-1:0] in_mask = '0;
  logic [OPSW-1:0] in_opsize = '0;
  logic [BANKW-1:0] in_bank = '0;
  logic [ROWW-1:0] in_row = '0;
  logic [COLW-1:0] in_col = '0;
  logic [GPRW-1:0] in_gpr = '0;
  logic req_valid, req_ready = 1'b0, req_last;
  logic [CHW-1:0] req_chan;
  logic [BANKW-1:0] req_bank;
  logic [ROWW-1:0] req_row;
  logic [COLW-1:0] req_col;
  logic [3:0] req_op;
  logic [GPRW-1:0] req_gpr;
  logic cmpl = 1'b0, err, done;

  int checks = 0, errors = 0;
  logic [PW-1:0] expq[$];
  bit exp_err = 0;
  int stall_pct = 40;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pim_dispatch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_mask_i(in_mask), .in_opsize_i(in_opsize),
    .in_bank_i(in_bank), .in_row_i(in_row), .in_col_i(in_col), .in_gpr_i(in_gpr),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_chan_o(req_chan),
    .req_bank_o(req_bank), .req_row_o(req_row), .req_col_o(req_col),
    .req_op_o(req_op), .req_gpr_o(req_gpr), .req_last_o(req_last),
    .cmpl_i(cmpl), .err_o(err), .done_o(done)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_sized(logic [3:0] op);
    return op inside {4'd2, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13};
  endfunction
  function automatic bit is_block(logic [3:0] op);
    return op inside {4'd4, 4'd5, 4'd14, 4'd15};
  endfunction
  function automatic bit no_req(logic [3:0] op);
    return op inside {4'd14, 4'd15};
  endfunction

  // monitor: ready driven at negedge, handshake judged before next posedge
  always @(negedge clk) begin
    req_ready = ($urandom_range(0, 99) >= stall_pct);
    #1;
    if (rst_n && req_valid) begin
      chk(!in_ready, "R7 ready while busy", 64'(in_ready), 64'd0);
      if (req_ready) begin
        logic [PW-1:0] act;
        act = {req_chan, req_bank, req_row, req_col, req_op, req_gpr, req_last};
        if (expq.size() == 0) begin
          chk(0, "R2/R11 unexpected request", 64'(act), 64'd0);
        end else begin
          logic [PW-1:0] e;
          e = expq.pop_front();
          chk(act == e, "R2/R3/R8/R9 request", 64'(act), 64'(e));
        end
      end
    end
  end

  task automatic model(logic [3:0] op, logic [NCH-1:0] m, logic [OPSW-1:0] sz,
                       logic [BANKW-1:0] bk, logic [ROWW-1:0] rw,
                       logic [COLW-1:0] c, logic [GPRW-1:0] g);
    int n, hi;
    if (no_req(op)) return;
    n = is_sized(op) ? int'(sz) + 1 : 1;
    hi = -1;
    for (int i = 0; i < NCH; i++) if (m[i]) hi = i;
    for (int ch = 0; ch < NCH; ch++) begin
      if (m[ch]) begin
        for (int b = 0; b < n; b++) begin
          logic [COLW-1:0] cc;
          cc = c + COLW'(b);
          expq.push_back({CHW'(ch), bk, rw, cc, op, g, (ch == hi) && (b == n - 1)});
        end
      end
    end
  endtask

  task automatic send(logic [3:0] op, logic [NCH-1:0] m, logic [OPSW-1:0] sz,
                      logic [BANKW-1:0] bk, logic [ROWW-1:0] rw,
                      logic [COLW-1:0] c, logic [GPRW-1:0] g);
    bit bad;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_mask = m; in_opsize = sz;
    in_bank = bk; in_row = rw; in_col = c; in_gpr = g;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    bad = (op == 4'd1) && ($countones(m) != 1);
    if (bad) exp_err = 1;
    else model(op, m, sz, bk, rw, c, g);
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    if (bad) begin
      chk(err == 1'b1, "R4 err after illegal all-bank mask", 64'(err), 64'd1);
      chk(in_ready == 1'b1, "R4 dropped instruction frees port", 64'(in_ready), 64'd1);
    end else if (!is_block(op) && (m == '0 || no_req(op))) begin
      chk(in_ready == 1'b1, "R11 empty mask ready next cycle", 64'(in_ready), 64'd1);
    end
    if (!bad && is_block(op)) begin
      while (expq.size() != 0) begin @(negedge clk); #2; end
      repeat (3) begin
        @(negedge clk);
        chk(in_ready == 1'b0, "R5 blocked until completion", 64'(in_ready), 64'd0);
      end
      cmpl = 1'b1;
      @(negedge clk);
      cmpl = 1'b0;
      #2;
      chk(in_ready == (op != 4'd15), "R5 ready after completion", 64'(in_ready),
          64'(op != 4'd15));
      chk(done == (op == 4'd15), "R6 done flag", 64'(done), 64'(op == 4'd15));
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    #2;
    chk(in_ready == 1'b1, "R1 reset ready", 64'(in_ready), 64'd1);
    chk(req_valid == 1'b0, "R1 reset valid", 64'(req_valid), 64'd0);
    chk(err == 1'b0 && done == 1'b0, "R1 reset flags", 64'({err, done}), 64'd0);
    rst_n = 1'b1;

    // R12: stray completion while idle
    @(negedge clk); cmpl = 1'b1;
    @(negedge clk); cmpl = 1'b0; #2;
    chk(in_ready == 1'b1 && done == 1'b0, "R12 stray completion ignored",
        64'({in_ready, done}), 64'b10);

    send(4'd0, 32'h1, 4'd9, 4'd3, 14'h123, 6'd5, 3'd2);         // unsized: 1 beat
    send(4'd10, 32'h8000_0011, 4'd3, 4'd7, 14'h3abc, 6'd62, 3'd6); // R3 wrap, both ends
    drain();
    send(4'd1, 32'h0, 4'd0, 4'd1, 14'h1, 6'd0, 3'd0);           // R4 empty
    send(4'd1, 32'h3, 4'd0, 4'd1, 14'h1, 6'd0, 3'd0);           // R4 two bits
    send(4'd1, 32'h0000_0400, 4'd5, 4'd2, 14'h2, 6'd1, 3'd1);   // legal all-bank
    send(4'd4, 32'h5, 4'd0, 4'd9, 14'h77, 6'd10, 3'd4);         // R5 MAC read
    send(4'd14, 32'hffff_ffff, 4'd0, 4'd0, 14'h0, 6'd0, 3'd0);  // R11 barrier
    send(4'd13, 32'h0, 4'd7, 4'd0, 14'h0, 6'd0, 3'd0);          // R11 empty mask
    send(4'd5, 32'h0, 4'd0, 4'd0, 14'h0, 6'd0, 3'd0);           // R5 empty blocking
    drain();
    chk(err == 1'b1, "R4 err stays set", 64'(err), 64'd1);

    for (int k = 0; k < 220; k++) begin
      logic [3:0] op;
      logic [NCH-1:0] m;
      stall_pct = int'($urandom_range(0, 70));
      op = 4'($urandom_range(0, 14));
      m = $urandom() & $urandom() & $urandom();
      if (op == 4'd1 && $urandom_range(0, 1) == 1) m = NCH'(1) << $urandom_range(0, NCH - 1);
      send(op, m, 4'($urandom()), 4'($urandom()), 14'($urandom()),
           6'($urandom()), 3'($urandom()));
    end
    drain();
    chk(expq.size() == 0, "R2 all expected requests seen", 64'(expq.size()), 64'd0);
    chk(err == exp_err, "R4 err matches model", 64'(err), 64'(exp_err));

    send(4'd15, 32'h0, 4'd0, 4'd0, 14'h0, 6'd0, 3'd0);          // R6 end
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd0; in_mask = 32'h1;
    repeat (10) begin
      @(negedge clk); #2;
      chk(in_ready == 1'b0 && done == 1'b1, "R6 no accept after end",
          64'({in_ready, done}), 64'b01);
    end
    in_valid = 1'b0;
    chk(req_valid == 1'b0, "R6 no request after end", 64'(req_valid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule